// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the settings a clock synthesizer needs: a 9-bit feedback divider value M, a 2-bit output divider code N and a 3-bit test selector T. These values can be written through a parallel port or a three-wire serial port. The serial port has a data line, a shift clock and a load strobe.

All strobe inputs are sampled by the system clock `clk` and are assumed to be synchronous to it. Edges on the strobes are found by comparing each input with its value in the previous cycle. The outputs update on the same `clk` edge that sees the event. If both load paths are used, the most recent event wins.

A flag marks feedback values too small for the loop to lock. A single test pin shows the oldest bit of the shift register or a fixed level, depending on T.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, the block resets: the shift register becomes 0, `t_val` 000, `n_val` 00, `m_val` 250, `m_invalid` 0 and `test_out` 0.
- R2: A rising edge on `ser_clk` with `par_load_n` high and `ser_load` low shifts `ser_data` into bit 0 of the 14-bit shift register. Older bits move one place toward bit 13. `m_val`, `n_val` and `t_val` do not change.
- R3: A serial frame is 14 bits sent most significant first, in this order: T[2:0], N[1:0], M[8:0]. After 14 shifts, register bits 13:11 hold T, bits 10:9 hold N and bits 8:0 hold M.
- R4: A rising edge on `ser_load` with `par_load_n` high copies the shift register fields into `t_val`, `n_val` and `m_val`.
- R5: While `ser_load` is high and `par_load_n` is high, each rising edge on `ser_clk` shifts the register. The newly shifted fields are copied into `t_val`, `n_val` and `m_val` on the same edge.
- R6: After `ser_load` falls, the loaded values hold. Further `ser_clk` edges with `ser_load` low change only the shift register.
- R7: While `par_load_n` is low, `m_val` and `n_val` take `par_m` and `par_n` on each `clk` edge and `t_val` is forced to 000. Serial clock and load activity is ignored, and the shift register keeps its contents.
- R8: After `par_load_n` rises, the parallel values stay latched. Later changes on `par_m` and `par_n` have no effect until `par_load_n` goes low again or a serial load event occurs.
- R9: `test_out` depends on `t_val`. For 001 it is 1. For 101 it is 0. For every other code it shows shift register bit 13.
- R10: `m_invalid` is 1 exactly when `m_val` is below 250. Values 250 to 511 are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe |
| par_load_n | input | 1 | Parallel load, active low, transparent while low |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel output divider code |
| m_val | output | 9 | Registered feedback divider value |
| n_val | output | 2 | Registered output divider code |
| t_val | output | 3 | Registered test selector |
| test_out | output | 1 | Test pin output |
| m_invalid | output | 1 | High when `m_val` is below the lockable range |

## Verification
Random serial frames with random T, N and M are sent and then loaded with a load pulse. A field mapped to the wrong bits, or a value that changes before the pulse, shows up as a wrong output.

The load strobe is also held high while bits are shifted, which separates the pass-through behaviour from the pulse-and-hold behaviour. Parallel mode is exercised with random values while serial activity is injected at the same time. The values latched afterwards are then checked while the parallel pins change.

A later serial load brings out the whole shift register through the outputs, which shows that parallel mode did not disturb it. Directed M values of 0, 249, 250 and 511 probe the edge of the lock range.

// File: rtl/divcfg_pkg.sv
// Package divcfg_pkg
// Shared widths, reset values and test-selector codes for the divider
// configuration loader. Assumes a 9-bit M, 2-bit N and 3-bit T.
package divcfg_pkg;
    localparam int M_W      = 9;
    localparam int N_W      = 2;
    localparam int T_W      = 3;
    localparam int FRAME_W  = T_W + N_W + M_W;
    localparam int M_RESET  = 250;
    localparam int M_LOCK_MIN = 250;

    typedef enum logic [T_W-1:0] {
        TSEL_SHIFT = 3'b000,
        TSEL_HIGH  = 3'b001,
        TSEL_LOW   = 3'b101
    } tsel_e;
endpackage

// File: rtl/divcfg_edge.sv
// Module divcfg_edge
// Finds rising edges on a group of strobes that are synchronous to clk.
// Assumes each strobe is low when the block leaves reset.
module divcfg_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] sig_q;

    // Hold each strobe's value from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        // A strobe that is high now and was low before has a rising edge.
        assign rise[i] = sig[i] & ~sig_q[i];
    end
endmodule

// File: rtl/divcfg_shifter.sv
// Module divcfg_shifter
// Serial shift register. The newest bit enters bit 0.
// Exposes both the current contents and the value after this cycle's shift.
module divcfg_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sh_q,
    output logic [W-1:0] sh_d
);
    // The next value: shifted when enabled, otherwise unchanged.
    always_comb begin
        sh_d = shift_en ? {sh_q[W-2:0], din} : sh_q;
    end

    // Register the shift chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R2: an enabled shift moves the old bits up and appends the input bit.
    assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sh_q == {$past(sh_q[W-2:0]), $past(din)});
endmodule

// File: rtl/divcfg_test_sel.sv
// Module divcfg_test_sel
// Chooses the test pin level from the test selector. Only codes
// 001 and 101 force a fixed level; all others show the shift-register MSB.
module divcfg_test_sel
    import divcfg_pkg::*;
(
    input  logic [T_W-1:0] tsel,
    input  logic           sh_msb,
    output logic           test_out
);
    // Decode the selector code.
    always_comb begin
        case (tsel)
            TSEL_HIGH: test_out = 1'b1;
            TSEL_LOW:  test_out = 1'b0;
            default:   test_out = sh_msb;
        endcase
    end
endmodule

// File: rtl/divcfg_loader.sv
// Module divcfg_loader
// Holds M, N and T and accepts them from a parallel port or a three-wire
// serial port. All strobes are assumed synchronous to clk. Parallel mode
// (par_load_n low) takes precedence within a cycle; otherwise the most
// recent event wins.
module divcfg_loader
    import divcfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_val,
    output logic [T_W-1:0] t_val,
    output logic           test_out,
    output logic           m_invalid
);
    localparam logic [M_W-1:0] M_RST_V = M_W'(M_RESET);
    localparam logic [M_W-1:0] M_MIN_V = M_W'(M_LOCK_MIN);

    logic [1:0]         rise;
    logic               sclk_rise;
    logic               sload_rise;
    logic               shift_en;
    logic               take_serial;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] sh_d;

    divcfg_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({ser_load, ser_clk}),
        .rise (rise)
    );

    assign sclk_rise   = rise[0];
    assign sload_rise  = rise[1];
    assign shift_en    = par_load_n & sclk_rise;
    assign take_serial = par_load_n & (sload_rise | (ser_load & sclk_rise));

    divcfg_shifter #(.W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (ser_data),
        .sh_q    (sh_q),
        .sh_d    (sh_d)
    );

    // Update the divider registers from the parallel pins or the serial frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_val <= M_RST_V;
            n_val <= '0;
            t_val <= '0;
        end else if (!par_load_n) begin
            m_val <= par_m;
            n_val <= par_n;
            t_val <= '0;
        end else if (take_serial) begin
            t_val <= sh_d[FRAME_W-1 -: T_W];
            n_val <= sh_d[M_W +: N_W];
            m_val <= sh_d[M_W-1:0];
        end
    end

    assign m_invalid = (m_val < M_MIN_V);

    divcfg_test_sel u_tsel (
        .tsel    (t_val),
        .sh_msb  (sh_q[FRAME_W-1]),
        .test_out(test_out)
    );

    // R1: reset puts the registers in their defined start state.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (m_val == M_RST_V && n_val == '0 && t_val == '0 && sh_q == '0));

    // R6: with the load strobe low in serial mode, the loaded values hold.
    assert_hold_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && par_load_n && !ser_load) |=>
            ($stable(m_val) && $stable(n_val) && $stable(t_val)));

    // R7: parallel mode copies the pins and clears the test selector.
    assert_par_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !par_load_n) |=>
            (m_val == $past(par_m) && n_val == $past(par_n) && t_val == '0));

    // R7: parallel mode leaves the shift register untouched.
    assert_par_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !par_load_n) |=> $stable(sh_q));
endmodule

// File: tb/divcfg_loader_bench.sv
module divcfg_loader_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic       par_load_n = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [8:0] m_val;
    logic [1:0] n_val;
    logic [2:0] t_val;
    logic       test_out, m_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [13:0] e_sh = '0;
    logic [8:0]  e_m = 9'd250;
    logic [1:0]  e_n = '0;
    logic [2:0]  e_t = '0;

    divcfg_loader u_divcfg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .par_load_n(par_load_n), .par_m(par_m),
        .par_n(par_n), .m_val(m_val), .n_val(n_val), .t_val(t_val),
        .test_out(test_out), .m_invalid(m_invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_test(logic [2:0] t, logic [13:0] sh);
        if (t == 3'b001) return 1'b1;
        if (t == 3'b101) return 1'b0;
        return sh[13];
    endfunction

    function automatic logic exp_inv(logic [8:0] m);
        return m < 9'd250;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " m"}, m_val, e_m);
        chk({tag, " n"}, n_val, e_n);
        chk({tag, " t"}, t_val, e_t);
        chk({tag, " test R9"}, test_out, exp_test(e_t, e_sh));
        chk({tag, " invalid R10"}, m_invalid, exp_inv(e_m));
    endtask

    task automatic ser_bit(logic b, bit pass);
        @(negedge clk); ser_data = b; ser_clk = 1'b1;
        e_sh = {e_sh[12:0], b};
        if (pass) begin e_t = e_sh[13:11]; e_n = e_sh[10:9]; e_m = e_sh[8:0]; end
        @(negedge clk); ser_clk = 1'b0;
    endtask

    task automatic send_frame(logic [2:0] t, logic [1:0] n, logic [8:0] m);
        logic [13:0] f;
        f = {t, n, m};
        for (int i = 13; i >= 0; i--) ser_bit(f[i], 1'b0);
    endtask

    task automatic pulse_load();
        @(negedge clk); ser_load = 1'b1;
        e_t = e_sh[13:11]; e_n = e_sh[10:9]; e_m = e_sh[8:0];
        @(negedge clk); ser_load = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        chk_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: random frames, outputs hold until the load pulse
        for (int k = 0; k < 20; k++) begin
            logic [2:0] t; logic [1:0] n; logic [8:0] m;
            logic [8:0] pm; logic [1:0] pn; logic [2:0] pt;
            t = 3'($urandom); n = 2'($urandom); m = 9'($urandom);
            pm = e_m; pn = e_n; pt = e_t;
            send_frame(t, n, m);
            chk("R2 hold m", m_val, pm);
            chk("R2 hold t", t_val, pt);
            chk("R9 test during shift", test_out, exp_test(pt, e_sh));
            pulse_load();
            chk("R3 field t", t_val, t);
            chk("R3 field n", n_val, n);
            chk("R4 load m", m_val, m);
            chk_all("R4 frame");
        end

        // R6: shifting after the strobe falls leaves the loaded values
        send_frame(3'b000, 2'b10, 9'd300);
        pulse_load();
        for (int i = 0; i < 5; i++) ser_bit(1'($urandom), 1'b0);
        chk_all("R6 after fall");

        // R5: pass-through while the strobe is held high
        @(negedge clk); ser_load = 1'b1;
        e_t = e_sh[13:11]; e_n = e_sh[10:9]; e_m = e_sh[8:0];
        @(negedge clk);
        chk_all("R5 rise");
        for (int i = 0; i < 10; i++) begin
            ser_bit(1'($urandom), 1'b1);
            chk_all("R5 pass");
        end
        @(negedge clk); ser_load = 1'b0;
        @(negedge clk);
        chk_all("R6 strobe low");

        // R10 boundaries
        foreach (int_list[i]) begin end
        for (int i = 0; i < 4; i++) begin
            logic [8:0] mv;
            mv = (i == 0) ? 9'd0 : (i == 1) ? 9'd249 : (i == 2) ? 9'd250 : 9'd511;
            send_frame(3'b000, 2'b01, mv);
            pulse_load();
            chk("R10 boundary", m_invalid, exp_inv(mv));
            chk("R10 m", m_val, mv);
        end

        // R7: parallel mode follows pins, forces T to 000, ignores serial
        send_frame(3'b001, 2'b11, 9'd400);
        pulse_load();
        chk("R9 forced high", test_out, 1);
        par_load_n = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            par_m = 9'($urandom); par_n = 2'($urandom);
            ser_clk = 1'($urandom); ser_data = 1'($urandom); ser_load = 1'($urandom);
            e_m = par_m; e_n = par_n; e_t = 3'b000;
            @(negedge clk);
            chk_all("R7 parallel");
        end
        @(negedge clk); ser_clk = 1'b0; ser_load = 1'b0;
        @(negedge clk); par_load_n = 1'b1;

        // R8: latched values survive pin changes
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); par_m = 9'($urandom); par_n = 2'($urandom);
            @(negedge clk);
            chk_all("R8 latched");
        end
        // R8 R7: a serial load overrides and shows the untouched shift register
        pulse_load();
        chk_all("R8 serial override");
        chk("R7 shift kept", {t_val, n_val, m_val}, {3'b001, 2'b11, 9'd400});

        // R9: low-forcing code
        send_frame(3'b101, 2'b00, 9'd260);
        pulse_load();
        chk("R9 forced low", test_out, 0);
        send_frame(3'b110, 2'b00, 9'd260);
        pulse_load();
        chk_all("R9 other code");

        // R1: reset from a loaded state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        e_sh = '0; e_m = 9'd250; e_n = '0; e_t = '0;
        chk_all("R1 second reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int int_list[1] = '{0};

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule